// File: doc/BRIEF.md
# Self-Synchronising Bit-Serial Payload Scrambler

This block whitens the payload portion of a fixed-size cell stream, one bit per clock, with the self-synchronising polynomial x^43+1. It keeps a history of the last DELAY line bits. Each payload bit leaves as the incoming bit XORed with the line bit seen DELAY payload bits before. One static mode pin sets the direction. In scramble mode the history is fed with the bit that goes onto the line. In descramble mode it is fed with the bit received from the line. Because both ends fill their history from the same line bits, a receiver that starts from arbitrary contents matches the transmitter after DELAY payload bits, with no reset or alignment message.

An upstream framer marks header bits with a flag. Header bits are copied to the output without change, and the history does not advance for them. Invalid cycles are gaps: they change nothing and produce no output. Every output goes through one register stage, which sits outside the feedback loop, so the loop delay is exactly DELAY payload bits.

Top module: `ssync_scrambler`

## Requirements
- R1: For a valid payload bit (in_vld=1, in_hdr=0), out_bit on the following cycle equals in_bit XOR the oldest history stage, which is the line bit from DELAY payload bits earlier.
- R2: With mode_i=0 (scramble), the bit shifted into the history for a payload bit is the produced output bit.
- R3: With mode_i=1 (descramble), the bit shifted into the history for a payload bit is the received in_bit, not the produced output.
- R4: A valid header bit (in_hdr=1) appears unchanged on out_bit one cycle later, and the history does not shift.
- R5: While in_vld=0 the history holds its contents, and out_vld is 0 on the following cycle.
- R6: out_vld equals in_vld delayed by exactly one clock. A synchronous reset (rst=1) clears out_vld and every history stage.
- R7: From the cleared state, the first DELAY payload bits leave a scrambler unchanged.
- R8: Consider a scrambler and a descrambler connected back to back, with the header flag delayed by one cycle between them. If they start from different history contents, the descrambler output equals the original payload from the (DELAY+1)-th payload bit on. Header bits match from the first bit.
- R9: The parameter DELAY (default 43, at least 1) sets the history length. A pair built with a short DELAY (for example 4) still recovers the data exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 0 = scramble, 1 = descramble |
| in_bit | input | 1 | Serial data bit |
| in_vld | input | 1 | in_bit is valid this cycle |
| in_hdr | input | 1 | in_bit is a header bit (bypassed) |
| out_bit | output | 1 | Serial result bit, registered |
| out_vld | output | 1 | out_bit is valid this cycle |

## Verification
The hardest case to reach is two ends whose histories disagree. A common reset clears both, so from the ports they always start equal. To separate them, the bench first streams random bits into the descrambler alone while the scrambler sits idle. It then sends cells of 40 header bits and 384 payload bits through both ends, with random gaps. Header bits are compared from the first bit, and payload bits from the 44th payload bit on. A short DELAY=4 pair is checked against a worked table that mixes in header bits and idle cycles.

// File: rtl/ssync_scr_pkg.sv
package ssync_scr_pkg;
   typedef enum logic {
      MODE_SCRAMBLE   = 1'b0,
      MODE_DESCRAMBLE = 1'b1
   } scr_mode_e;

   localparam int unsigned DELAY_DEFAULT = 43;
endpackage

// File: rtl/ssync_hist.sv
module ssync_hist #(
   parameter int unsigned DEPTH = 43
) (
   input  logic clk,
   input  logic rst,
   input  logic shift_i,
   input  logic feed_i,
   output logic oldest_o,
   output logic youngest_o
);
   generate
      if (DEPTH < 1) begin : g_bad
         $error("ssync_hist: DEPTH must be at least 1");
         assign oldest_o   = 1'b0;
         assign youngest_o = 1'b0;
      end else if (DEPTH == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk) begin
            if (rst)          stage_q <= 1'b0;
            else if (shift_i) stage_q <= feed_i;
         end
         assign oldest_o   = stage_q;
         assign youngest_o = stage_q;
      end else begin : g_chain
         logic [DEPTH-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (rst)          stage_q <= '0;
            else if (shift_i) stage_q <= {stage_q[DEPTH-2:0], feed_i};
         end
         assign oldest_o   = stage_q[DEPTH-1];
         assign youngest_o = stage_q[0];
      end
   endgenerate

   // R5
   hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !shift_i |=> ($stable(oldest_o) && $stable(youngest_o)));
endmodule

// File: rtl/ssync_mix.sv
module ssync_mix
   import ssync_scr_pkg::*;
(
   input  scr_mode_e mode_i,
   input  logic      bit_i,
   input  logic      hdr_i,
   input  logic      oldest_i,
   output logic      res_o,
   output logic      feed_o
);
   logic mixed;

   always_comb begin
      mixed  = bit_i ^ oldest_i;
      res_o  = hdr_i ? bit_i : mixed;
      feed_o = (mode_i == MODE_SCRAMBLE) ? mixed : bit_i;
   end
endmodule

// File: rtl/ssync_outreg.sv
module ssync_outreg (
   input  logic clk,
   input  logic rst,
   input  logic vld_i,
   input  logic bit_i,
   output logic vld_o,
   output logic bit_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o <= 1'b0;
         bit_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) bit_o <= bit_i;
      end
   end

   // R6
   vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      vld_i |=> vld_o);
   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> (!vld_o && $stable(bit_o)));
endmodule

// File: rtl/ssync_scrambler.sv
module ssync_scrambler
   import ssync_scr_pkg::*;
#(
   parameter int unsigned DELAY = DELAY_DEFAULT
) (
   input  logic clk,
   input  logic rst,
   input  logic mode_i,
   input  logic in_bit,
   input  logic in_vld,
   input  logic in_hdr,
   output logic out_bit,
   output logic out_vld
);
   scr_mode_e mode;
   logic      advance;
   logic      oldest;
   logic      youngest;
   logic      res;
   logic      feed;

   assign mode    = scr_mode_e'(mode_i);
   assign advance = in_vld & ~in_hdr;

   ssync_hist #(.DEPTH(DELAY)) u_hist (
      .clk       (clk),
      .rst       (rst),
      .shift_i   (advance),
      .feed_i    (feed),
      .oldest_o  (oldest),
      .youngest_o(youngest)
   );

   ssync_mix u_mix (
      .mode_i  (mode),
      .bit_i   (in_bit),
      .hdr_i   (in_hdr),
      .oldest_i(oldest),
      .res_o   (res),
      .feed_o  (feed)
   );

   ssync_outreg u_out (
      .clk  (clk),
      .rst  (rst),
      .vld_i(in_vld),
      .bit_i(res),
      .vld_o(out_vld),
      .bit_o(out_bit)
   );

   // R1
   payload_mix_chk: assert property (@(posedge clk) disable iff (rst)
      advance |=> (out_bit == ($past(in_bit) ^ $past(oldest))));
   // R2
   scr_feed_chk: assert property (@(posedge clk) disable iff (rst)
      (advance && !mode_i) |=> (youngest == out_bit));
   // R3
   dscr_feed_chk: assert property (@(posedge clk) disable iff (rst)
      (advance && mode_i) |=> (youngest == $past(in_bit)));
   // R4
   hdr_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_hdr) |=> (out_bit == $past(in_bit) && $stable(oldest)));
endmodule

// File: tb/ssync_scrambler_bench.sv
module ssync_scrambler_bench;
   localparam int DLY = 43;
   localparam int SDLY = 4;
   localparam int NVEC = 18;
   // entries are {hdr, in_bit, expected scrambled bit} for DELAY=4
   localparam logic [2:0] VEC [NVEC] = '{
      3'b000, 3'b011, 3'b011, 3'b011, 3'b000, 3'b010, 3'b010, 3'b010,
      3'b111, 3'b100,
      3'b000, 3'b000, 3'b011, 3'b011, 3'b011, 3'b000, 3'b001, 3'b010
   };

   typedef struct packed {
      logic        hdr;
      logic        b;
      logic [15:0] idx;
   } ent_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   int n_run  = 0;
   int n_fail = 0;

   // large pair
   logic a_bit = 0, a_vld = 0, a_hdr = 0;
   logic t_bit, t_vld, t_hdr;
   logic prime = 0, p_bit = 0, p_vld = 0;
   logic rx_bit, rx_vld, rx_hdr;
   logic r_bit, r_vld;
   // small pair
   logic s_bit = 0, s_vld = 0, s_hdr = 0;
   logic st_bit, st_vld, st_hdr;
   logic sr_bit, sr_vld;

   logic stream_on = 0;
   logic small_on = 0;
   ent_t q_tx[$];
   ent_t q_rx[$];
   ent_t q_sm[$];

   assign rx_bit = prime ? p_bit : t_bit;
   assign rx_vld = prime ? p_vld : t_vld;
   assign rx_hdr = prime ? 1'b0  : t_hdr;

   always_ff @(posedge clk) begin
      t_hdr  <= a_hdr;
      st_hdr <= s_hdr;
   end

   ssync_scrambler #(.DELAY(DLY)) u_ssync_scrambler (
      .clk(clk), .rst(rst), .mode_i(1'b0),
      .in_bit(a_bit), .in_vld(a_vld), .in_hdr(a_hdr),
      .out_bit(t_bit), .out_vld(t_vld));
   ssync_scrambler #(.DELAY(DLY)) u_rx (
      .clk(clk), .rst(rst), .mode_i(1'b1),
      .in_bit(rx_bit), .in_vld(rx_vld), .in_hdr(rx_hdr),
      .out_bit(r_bit), .out_vld(r_vld));
   ssync_scrambler #(.DELAY(SDLY)) u_small_tx (
      .clk(clk), .rst(rst), .mode_i(1'b0),
      .in_bit(s_bit), .in_vld(s_vld), .in_hdr(s_hdr),
      .out_bit(st_bit), .out_vld(st_vld));
   ssync_scrambler #(.DELAY(SDLY)) u_small_rx (
      .clk(clk), .rst(rst), .mode_i(1'b1),
      .in_bit(st_bit), .in_vld(st_vld), .in_hdr(st_hdr),
      .out_bit(sr_bit), .out_vld(sr_vld));

   task automatic check(input logic ok, input string tag, input logic act, input logic exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   // stream checkers
   always @(negedge clk) begin
      ent_t e;
      if (stream_on) begin
         if (t_vld && q_tx.size() > 0) begin
            e = q_tx.pop_front();
            if (e.hdr)
               check(t_bit == e.b, "R4 tx header bypass", t_bit, e.b);
            else if (int'(e.idx) < DLY)
               check(t_bit == e.b, "R7 tx first payload unchanged", t_bit, e.b);
         end
         if (r_vld && q_rx.size() > 0) begin
            e = q_rx.pop_front();
            if (e.hdr)
               check(r_bit == e.b, "R4 rx header bypass", r_bit, e.b);
            else if (int'(e.idx) >= DLY)
               check(r_bit == e.b, "R8 R3 recovered payload", r_bit, e.b);
         end
      end
      if (small_on && sr_vld && q_sm.size() > 0) begin
         e = q_sm.pop_front();
         check(sr_bit == e.b, "R9 R3 short pair recovery", sr_bit, e.b);
      end
   end

   initial begin
      #(4 * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      finish_run();
   end

   initial begin
      logic prev_idle;
      logic [15:0] pidx;
      logic b;
      ent_t e;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R6 reset state
      check(!t_vld && !r_vld && !st_vld && !sr_vld, "R6 out_vld low after reset", t_vld, 1'b0);

      // table walk on the DELAY=4 pair
      small_on = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         s_hdr = VEC[i][2];
         s_bit = VEC[i][1];
         s_vld = 1'b1;
         e.hdr = VEC[i][2]; e.b = VEC[i][1]; e.idx = 16'(i);
         q_sm.push_back(e);
         @(negedge clk);
         if (VEC[i][2])
            check(st_bit == VEC[i][0], "R4 short header bypass", st_bit, VEC[i][0]);
         else
            check(st_bit == VEC[i][0], "R1 R2 short scramble table", st_bit, VEC[i][0]);
         if (i % 5 == 4) begin
            s_vld = 1'b0;
            s_bit = ~s_bit;
            @(negedge clk);
            check(!st_vld, "R5 out_vld low after gap", st_vld, 1'b0);
         end
      end
      s_vld = 1'b0;
      repeat (4) @(negedge clk);
      small_on = 1'b0;

      // prime the descrambler alone so the histories differ
      prime = 1'b1;
      for (int i = 0; i < 60; i++) begin
         p_bit = 1'($urandom);
         p_vld = 1'b1;
         @(negedge clk);
      end
      p_vld = 1'b0;
      @(negedge clk);
      prime = 1'b0;
      repeat (3) @(negedge clk);

      // cell stream: 40 header bits then 384 payload bits, random gaps
      stream_on = 1'b1;
      pidx = '0;
      prev_idle = 1'b0;
      for (int c = 0; c < 3; c++) begin
         for (int k = 0; k < 424; k++) begin
            while (($urandom % 8) == 0) begin
               a_vld = 1'b0;
               a_bit = 1'($urandom);
               @(negedge clk);
               check(!t_vld, "R5 gap gives no output", t_vld, 1'b0);
            end
            b = 1'($urandom);
            a_bit = b;
            a_vld = 1'b1;
            a_hdr = (k < 40);
            e.hdr = a_hdr; e.b = b; e.idx = pidx;
            q_tx.push_back(e);
            q_rx.push_back(e);
            if (!a_hdr) pidx = pidx + 16'd1;
            @(negedge clk);
            check(t_vld, "R6 out_vld follows in_vld", t_vld, 1'b1);
         end
      end
      a_vld = 1'b0;
      a_hdr = 1'b0;
      repeat (4) @(negedge clk);
      stream_on = 1'b0;
      check(q_rx.size() == 0, "R8 all bits delivered", q_rx.size() == 0, 1'b1);

      // reset mid-life clears the history
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      check(!t_vld && !r_vld, "R6 reset clears out_vld", t_vld, 1'b0);
      for (int i = 0; i < DLY; i++) begin
         a_bit = 1'b1;
         a_vld = 1'b1;
         @(negedge clk);
         check(t_bit == 1'b1, "R6 R7 cleared history passes ones", t_bit, 1'b1);
      end
      a_bit = 1'b1;
      @(negedge clk);
      check(t_bit == 1'b0, "R1 R2 bit after DELAY ones", t_bit, 1'b0);
      a_vld = 1'b0;
      @(negedge clk);
      check(!t_vld, "R5 final idle", t_vld, 1'b0);

      finish_run();
   end
endmodule